// File: doc/BRIEF.md
# Power management wake aggregator

This block gathers sixteen wake event inputs into one active-low wake request for the platform's power sequencer. Each input has a sticky pending flag and an enable flag. A single global enable gates the combined request. The pending flags record every event, enabled or not, so software can always see what happened. The enables decide only whether an event may pull the request low.

Software reaches the block through a byte-wide register port with a 3-bit address. A write takes effect on the clock edge where `reg_wr_i` is high. Reads are combinational from `reg_addr_i`. The address map is:

| Address | Register |
| --- | --- |
| 0 | Pending bank A: sources 0..7, write-1-to-clear |
| 1 | Pending bank B: sources 8..15, write-1-to-clear |
| 2 | Enable bank A |
| 3 | Enable bank B |
| 4 | Control, bit 0 = global enable |
| 5 to 7 | Reserved |

In bank A, source 0 is reserved. The other bank A sources carry ring indicate 2, ring indicate 1, keyboard, mouse, specific-key wake, fan tach 1 and fan tach 2, on bits 1 to 7 in that order. Bank B bit i carries general-purpose input i.

The block has two synchronous active-low resets:
- `stby_rst_n` is the standby-power power-on reset. It clears everything.
- `main_rst_n` stands for main-power power-on, soft and hard resets. It clears the pending flags and the global enable, but leaves the enable registers untouched.

Top module: `pm_wake_agg`

## Requirements
- R1: `wake_n_o` is 0 exactly when the global enable (address 4, bit 0) is 1 and at least one source has both its enable bit and its pending bit set; otherwise it is 1.
- R2: A source whose enable bit is 0 still sets its pending bit on an event, and that pending bit leaves `wake_n_o` at 1.
- R3: Standby reset clears both enable registers to 0x00, both pending registers and the global enable.
- R4: Main reset leaves both enable registers unchanged.
- R5: Main reset clears both pending registers and the global enable.
- R6: A pending bit stays set until a write of 1 to that bit at its bank address; writing 0 to a pending bit has no effect.
- R7: When an event and a write-1-to-clear hit the same pending bit on the same edge, the bit ends up set.
- R8: Source 0 is reserved. Enable bank A bit 0 reads 0 and ignores writes, and pending bank A bit 0 never sets.
- R9: Addresses 5, 6 and 7 always read 0x00, and bits 7:1 of the control register read 0.
- R10: An event sampled high at a clock edge shows in the pending register, and when enabled, in `wake_n_o`, right after that same edge. Before that edge it has no effect.
- R11: `wake_evt_i[i]` maps to bank A bit i for i = 0..7, and `wake_evt_i[8+i]` maps to bank B bit i.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| stby_rst_n | input | 1 | Standby-power reset, synchronous, active low |
| main_rst_n | input | 1 | Main-power/soft/hard reset, synchronous, active low |
| wake_evt_i | input | 16 | Wake event inputs, active high, sampled each edge |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| wake_n_o | output | 1 | Aggregated wake request, active low |

## Verification
The combining function is tried with each gating term in turn:
- an event that is pending and enabled with the global enable off;
- an event that is pending with its enable off and the global enable on;
- an event with all three terms set.

Together these show that each term is needed on its own. Single events on one source in each bank show that the bit mapping is right and that bank A and bank B are not swapped. An event that arrives on the same edge as its own clear separates set-priority from clear-priority. A main reset applied with the enables and pending flags loaded distinguishes the two reset domains.

// File: rtl/pm_wake_pkg.sv
// Package pm_wake_pkg
// Shared register-kind encoding for the wake aggregator's register port.
// Assumes the address map is laid out as: pending banks, then enable banks,
// then one control register, then reserved space.
package pm_wake_pkg;

    typedef enum logic [1:0] {
        RK_PEND = 2'd0,
        RK_EN   = 2'd1,
        RK_CTRL = 2'd2,
        RK_NONE = 2'd3
    } reg_kind_e;

    // Classify an address given the number of banks.
    function automatic reg_kind_e classify(input int unsigned addr, input int unsigned banks);
        if (addr < banks)               return RK_PEND;
        else if (addr < 2 * banks)      return RK_EN;
        else if (addr == 2 * banks)     return RK_CTRL;
        else                            return RK_NONE;
    endfunction

endpackage

// File: rtl/pm_wake_enable.sv
// Module pm_wake_enable
// Holds the per-source enable registers, one byte per bank.
// Assumes its only reset is the standby-power reset. Main-domain resets never
// reach it. Bits cleared in IMPL_MASK are reserved: they read 0 and take no writes.
module pm_wake_enable #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8,
    parameter logic [NUM_BANKS*BANK_W-1:0] IMPL_MASK = '1
) (
    input  logic                        clk,
    input  logic                        stby_rst_n,
    input  logic [NUM_BANKS-1:0]        bank_wr_i,
    input  logic [BANK_W-1:0]           wdata_i,
    output logic [NUM_BANKS*BANK_W-1:0] en_o
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] en_q;

        // Load the bank on its write strobe; clear only on standby reset.
        always_ff @(posedge clk) begin
            if (!stby_rst_n)
                en_q <= '0;
            else if (bank_wr_i[b])
                en_q <= wdata_i & IMPL_MASK[b*BANK_W +: BANK_W];
        end

        assign en_o[b*BANK_W +: BANK_W] = en_q;
    end

endmodule

// File: rtl/pm_wake_status.sv
// Module pm_wake_status
// Keeps the sticky pending flags, one per source.
// Assumes events are sampled on every edge. A set on the same edge as a clear
// wins. Reserved sources (IMPL_MASK bit 0) never set.
module pm_wake_status #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8,
    parameter logic [NUM_BANKS*BANK_W-1:0] IMPL_MASK = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] evt_i,
    input  logic [NUM_BANKS*BANK_W-1:0] clr_i,
    output logic [NUM_BANKS*BANK_W-1:0] pend_o
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] BMASK = IMPL_MASK[b*BANK_W +: BANK_W];
        logic [BANK_W-1:0] pend_q;
        logic [BANK_W-1:0] evt_b;
        logic [BANK_W-1:0] clr_b;

        assign evt_b = evt_i[b*BANK_W +: BANK_W];
        assign clr_b = clr_i[b*BANK_W +: BANK_W];

        // Apply clears first, then set from events so a new event wins.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q <= '0;
            else
                pend_q <= ((pend_q & ~clr_b) | evt_b) & BMASK;
        end

        assign pend_o[b*BANK_W +: BANK_W] = pend_q;
    end

endmodule

// File: rtl/pm_wake_regif.sv
// Module pm_wake_regif
// Decodes the byte-wide register port and muxes the read data. Also holds the
// global enable bit, which lives in the main reset domain.
// Assumes combinational reads and writes on the edge where the strobe is high.
module pm_wake_regif
    import pm_wake_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 3
) (
    input  logic                        clk,
    input  logic                        main_rst_n,
    input  logic                        wr_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [BANK_W-1:0]           wdata_i,
    input  logic [NUM_BANKS*BANK_W-1:0] en_i,
    input  logic [NUM_BANKS*BANK_W-1:0] pend_i,
    output logic [NUM_BANKS-1:0]        en_wr_o,
    output logic [NUM_BANKS*BANK_W-1:0] pend_clr_o,
    output logic                        gbl_en_o,
    output logic [BANK_W-1:0]           rdata_o
);

    localparam int EN_BASE  = NUM_BANKS;
    localparam int CTRL_IDX = 2 * NUM_BANKS;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_IDX);

    logic [NUM_BANKS-1:0] sel_pend;
    logic [NUM_BANKS-1:0] sel_en;
    logic                 sel_ctrl;
    logic                 gbl_q;
    reg_kind_e            kind;

    assign kind     = classify(int'(addr_i), NUM_BANKS);
    assign sel_ctrl = (kind == RK_CTRL) && (addr_i == CTRL_ADDR);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign sel_pend[b] = (kind == RK_PEND) && (addr_i == ADDR_W'(b));
        assign sel_en[b]   = (kind == RK_EN)   && (addr_i == ADDR_W'(EN_BASE + b));
        assign en_wr_o[b]  = wr_i && sel_en[b];
        assign pend_clr_o[b*BANK_W +: BANK_W] = (wr_i && sel_pend[b]) ? wdata_i : '0;
    end

    // Global enable register, cleared by the main-domain reset.
    always_ff @(posedge clk) begin
        if (!main_rst_n)
            gbl_q <= 1'b0;
        else if (wr_i && sel_ctrl)
            gbl_q <= wdata_i[0];
    end

    assign gbl_en_o = gbl_q;

    // Read mux: selected bank or control byte; zero for reserved space.
    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel_pend[b]) rdata_o = pend_i[b*BANK_W +: BANK_W];
            if (sel_en[b])   rdata_o = en_i[b*BANK_W +: BANK_W];
        end
        if (sel_ctrl) rdata_o = {{(BANK_W-1){1'b0}}, gbl_q};
    end

endmodule

// File: rtl/pm_wake_agg.sv
// Module pm_wake_agg (top)
// Collects wake events into sticky pending flags, gates them with per-source
// and global enables, and drives one active-low wake request.
// Assumes synchronous active-low resets. The pending flags and the global enable
// clear on either reset; the enables clear on standby reset only.
module pm_wake_agg #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 3,
    parameter logic [NUM_BANKS*BANK_W-1:0] IMPL_MASK = 16'hFFFE
) (
    input  logic                        clk,
    input  logic                        stby_rst_n,
    input  logic                        main_rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] wake_evt_i,
    input  logic                        reg_wr_i,
    input  logic [ADDR_W-1:0]           reg_addr_i,
    input  logic [BANK_W-1:0]           reg_wdata_i,
    output logic [BANK_W-1:0]           reg_rdata_o,
    output logic                        wake_n_o
);

    localparam int SRC_N = NUM_BANKS * BANK_W;

    logic [SRC_N-1:0]     en_all;
    logic [SRC_N-1:0]     pend_all;
    logic [SRC_N-1:0]     pend_clr;
    logic [NUM_BANKS-1:0] en_wr;
    logic                 gbl_en;
    logic                 main_dom_rst_n;

    assign main_dom_rst_n = stby_rst_n & main_rst_n;

    pm_wake_regif #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_regif (
        .clk        (clk),
        .main_rst_n (main_dom_rst_n),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .en_i       (en_all),
        .pend_i     (pend_all),
        .en_wr_o    (en_wr),
        .pend_clr_o (pend_clr),
        .gbl_en_o   (gbl_en),
        .rdata_o    (reg_rdata_o)
    );

    pm_wake_enable #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .IMPL_MASK(IMPL_MASK)) u_enable (
        .clk        (clk),
        .stby_rst_n (stby_rst_n),
        .bank_wr_i  (en_wr),
        .wdata_i    (reg_wdata_i),
        .en_o       (en_all)
    );

    pm_wake_status #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .IMPL_MASK(IMPL_MASK)) u_status (
        .clk    (clk),
        .rst_n  (main_dom_rst_n),
        .evt_i  (wake_evt_i),
        .clr_i  (pend_clr),
        .pend_o (pend_all)
    );

    // Combine the enabled pending flags into the active-low wake request.
    assign wake_n_o = ~(gbl_en & (|(en_all & pend_all)));

endmodule

// File: rtl/pm_wake_agg_chk.sv
// Module pm_wake_agg_chk
// Property checker bound to pm_wake_agg. It watches the reset domains, the
// pending flags and the read port.
module pm_wake_agg_chk #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 3,
    parameter logic [NUM_BANKS*BANK_W-1:0] IMPL_MASK = 16'hFFFE
) (
    input logic                        clk,
    input logic                        stby_rst_n,
    input logic                        main_rst_n,
    input logic                        reg_wr_i,
    input logic [ADDR_W-1:0]           reg_addr_i,
    input logic [BANK_W-1:0]           reg_rdata_o,
    input logic [NUM_BANKS*BANK_W-1:0] wake_evt_i,
    input logic                        wake_n_o,
    input logic [NUM_BANKS*BANK_W-1:0] en_all,
    input logic [NUM_BANKS*BANK_W-1:0] pend_all,
    input logic                        gbl_en
);

    localparam logic [ADDR_W-1:0] EN_LO   = ADDR_W'(NUM_BANKS);
    localparam logic [ADDR_W-1:0] EN_HI   = ADDR_W'(2 * NUM_BANKS);
    localparam logic [ADDR_W-1:0] RSV_LO  = ADDR_W'(2 * NUM_BANKS + 1);

    // R1
    gbl_off_chk: assert property (@(posedge clk) disable iff (!stby_rst_n || !main_rst_n)
        !gbl_en |-> wake_n_o);

    // R4
    en_keep_chk: assert property (@(posedge clk) disable iff (!stby_rst_n)
        !(reg_wr_i && reg_addr_i >= EN_LO && reg_addr_i < EN_HI) |=> $stable(en_all));

    // R5
    main_clr_chk: assert property (@(posedge clk) disable iff (!stby_rst_n)
        !main_rst_n |=> (pend_all == '0 && !gbl_en));

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!stby_rst_n || !main_rst_n)
        !reg_wr_i |=> ((pend_all & $past(pend_all)) == $past(pend_all)));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!stby_rst_n || !main_rst_n)
        (|(wake_evt_i & IMPL_MASK)) |=>
        ((pend_all & $past(wake_evt_i & IMPL_MASK)) == $past(wake_evt_i & IMPL_MASK)));

    // R9
    rsvd_rd_chk: assert property (@(posedge clk) disable iff (!stby_rst_n)
        (reg_addr_i >= RSV_LO) |-> (reg_rdata_o == '0));

endmodule

bind pm_wake_agg pm_wake_agg_chk #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)
) u_chk (
    .clk         (clk),
    .stby_rst_n  (stby_rst_n),
    .main_rst_n  (main_rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .wake_evt_i  (wake_evt_i),
    .wake_n_o    (wake_n_o),
    .en_all      (en_all),
    .pend_all    (pend_all),
    .gbl_en      (gbl_en)
);

// File: tb/pm_wake_agg_tb.sv
// Directed bench for pm_wake_agg: one task per scenario, each checks itself.
module pm_wake_agg_tb;

    logic        clk = 1'b0;
    logic        stby_rst_n = 1'b0;
    logic        main_rst_n = 1'b0;
    logic [15:0] wake_evt = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        wake_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pm_wake_agg u_dut (
        .clk         (clk),
        .stby_rst_n  (stby_rst_n),
        .main_rst_n  (main_rst_n),
        .wake_evt_i  (wake_evt),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .wake_n_o    (wake_n)
    );

    // Advance one edge; return 2 ns after it, away from the edge.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wake_chk(input string req, input logic exp);
        #1;
        chk(req, {7'd0, wake_n}, {7'd0, exp});
    endtask

    task automatic pulse(input logic [15:0] m);
        wake_evt = m;
        tick();
        wake_evt = '0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_chk("R3 reset value", 3'(a), 8'h00);
        wake_chk("R3 wake idle after reset", 1'b1);
    endtask

    task automatic t_mapping();
        wr(3'd3, 8'hA5);
        rd_chk("R11 enable bank B write", 3'd3, 8'hA5);
        pulse(16'h2000);
        rd_chk("R11 source 13 to bank B bit 5", 3'd1, 8'h20);
        rd_chk("R11 bank A untouched", 3'd0, 8'h00);
        wake_chk("R1 global enable off keeps wake high", 1'b1);
        wr(3'd4, 8'h01);
        rd_chk("R9 control upper bits read 0", 3'd4, 8'h01);
        wake_chk("R1 all three terms drive wake low", 1'b0);
        wr(3'd1, 8'h20);
        rd_chk("R6 bank B clear", 3'd1, 8'h00);
        wake_chk("R1 wake released after clear", 1'b1);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_masked();
        pulse(16'h0008);
        rd_chk("R2 masked source still pending", 3'd0, 8'h08);
        wake_chk("R2 masked source keeps wake high", 1'b1);
        wr(3'd2, 8'h08);
        wake_chk("R1 enabling pending source drives wake", 1'b0);
        wr(3'd0, 8'h00);
        rd_chk("R6 writing 0 keeps pending", 3'd0, 8'h08);
        wr(3'd0, 8'h08);
        rd_chk("R6 writing 1 clears pending", 3'd0, 8'h00);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_collide();
        pulse(16'h0010);
        wake_evt = 16'h0010;
        wr(3'd0, 8'h10);
        wake_evt = '0;
        rd_chk("R7 event beats clear", 3'd0, 8'h10);
        wr(3'd0, 8'h10);
        rd_chk("R7 later clear works", 3'd0, 8'h00);
    endtask

    task automatic t_reserved();
        wr(3'd2, 8'hFF);
        rd_chk("R8 reserved enable bit reads 0", 3'd2, 8'hFE);
        pulse(16'h0001);
        rd_chk("R8 reserved source never pends", 3'd0, 8'h00);
        wake_chk("R8 reserved source no wake", 1'b1);
        for (int a = 5; a < 8; a++) rd_chk("R9 reserved address", 3'(a), 8'h00);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_latency();
        wr(3'd2, 8'h20);
        wake_evt = 16'h0020;
        wake_chk("R10 no effect before edge", 1'b1);
        rd_chk("R10 pending not yet set", 3'd0, 8'h00);
        tick();
        wake_evt = '0;
        wake_chk("R10 wake right after edge", 1'b0);
        wr(3'd0, 8'h20);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_main_reset();
        wr(3'd2, 8'h0C);
        wr(3'd3, 8'h81);
        pulse(16'h0108);
        wake_chk("R1 wake before main reset", 1'b0);
        main_rst_n = 1'b0;
        tick();
        main_rst_n = 1'b1;
        rd_chk("R4 enable A kept", 3'd2, 8'h0C);
        rd_chk("R4 enable B kept", 3'd3, 8'h81);
        rd_chk("R5 pending A cleared", 3'd0, 8'h00);
        rd_chk("R5 pending B cleared", 3'd1, 8'h00);
        rd_chk("R5 global enable cleared", 3'd4, 8'h00);
        wake_chk("R5 wake released", 1'b1);
    endtask

    task automatic t_stby_reset();
        stby_rst_n = 1'b0;
        tick();
        stby_rst_n = 1'b1;
        rd_chk("R3 enable A cleared by standby reset", 3'd2, 8'h00);
        rd_chk("R3 enable B cleared by standby reset", 3'd3, 8'h00);
    endtask

    initial begin
        repeat (3) tick();
        stby_rst_n = 1'b1;
        main_rst_n = 1'b1;
        tick();
        t_reset();
        t_mapping();
        t_masked();
        t_collide();
        t_reserved();
        wr(3'd4, 8'h01);
        t_latency();
        t_main_reset();
        t_stby_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule